// File: doc/BRIEF.md
# Dual-Comparator Timer with PWM Output

This block is a timer peripheral with one up-counter and two compare values, A and P. It runs in one of four modes. Plain timer/counter mode only counts and raises flags. Compare-output mode drives a pin from the A match. PWM mode makes a free-running waveform. Single-pulse mode makes one pulse each time it is triggered.

In the counting modes the counter clears on a chosen comparator match. In the waveform modes one of the compare values acts as the period and the other as the duty. A swap bit decides which is which. A level bit and a polarity bit shape the pin separately. All controls are plain register-style levels, and the block has no streaming interface. The counter advances only in cycles where the count-enable strobe is high.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter is 0, all flags are 0, and the pin is 0 (mode code 00, timer/counter).
- R2: In modes 00, 01 and 10 the counter advances by one on each cycle with `run` and `cnt_en` both high. It holds while `run` is low. It is cleared to 0 in the cycle `run` goes from low to high, and that cycle is not a tick.
- R3: In modes 00 and 01 with `clr_sel`=1, a tick with the counter equal to `cmp_a` loads 0 instead of incrementing.
- R4: In modes 00 and 01 with `clr_sel`=0, a tick with the counter equal to a non-zero `cmp_p` loads 0. With `cmp_p`=0 the counter runs to all ones and wraps to 0, and that tick raises `flag_ovf`.
- R5: `flag_a`, `flag_p` and `flag_ovf` are registered. Each is high for the cycle after a tick in which the counter equalled `cmp_a`, equalled `cmp_p`, or was all ones, respectively.
- R6: In mode 01 the internal output holds `level` while `run` is low. On a tick with the counter equal to `cmp_a`, `act` changes it: 00 keep, 01 drive low, 10 drive high, 11 toggle.
- R7: In modes 01, 10 and 11 the pin is the internal output XOR `polarity`. In mode 00 the pin is 0 whatever `level` and `polarity` are.
- R8: In modes 10 and 11, `swap`=0 makes `cmp_p` the period and `cmp_a` the duty. `swap`=1 exchanges the two roles. In mode 10 the counter runs 0..period and then returns to 0, giving period+1 ticks per cycle.
- R9: In mode 10 the waveform is active while the counter is below the duty. A duty of 0 is never active. A duty at or above the period is always active. Active means the internal output equals `level`; inactive means it equals the inverse of `level`.
- R10: In mode 11, `trigger` while idle clears the counter and starts a pulse. While the pulse runs, each `cnt_en` cycle ticks. The output is active while the counter is below the duty. At the period the counter clears and the block goes idle. `trigger` during a pulse is ignored, and `run` plays no part.
- R11: `clr_sel` has no effect in modes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 timer, 01 compare output, 10 PWM, 11 single pulse |
| level | input | 1 | Starting level (01) or active level (10/11) |
| polarity | input | 1 | Invert the pin |
| swap | input | 1 | Exchange period/duty roles of A and P |
| clr_sel | input | 1 | Clear source: 1 = A match, 0 = P match or overflow |
| act | input | 2 | Compare-output action on A match |
| cmp_a | input | W | Compare value A |
| cmp_p | input | W | Compare value P |
| run | input | 1 | Counter run enable |
| cnt_en | input | 1 | Count strobe |
| trigger | input | 1 | Single-pulse start |
| pin | output | 1 | Output pin level |
| flag_a | output | 1 | A match pulse |
| flag_p | output | 1 | P match pulse |
| flag_ovf | output | 1 | Overflow pulse |

## Verification
A counter that is off by even one count shows up in the cycle after its next expected match. Either a flag rises one cycle early or late, or the PWM or pulse edge on `pin` moves by a cycle. A wrong compare-output or pulse state shows on `pin` in the same cycle, because the pin is a combinational function of that state and the current controls. An overflow path fault stays hidden until the counter reaches all ones, so one long run with `cmp_p` at zero exercises it.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'b00,
    MODE_CMPOUT = 2'b01,
    MODE_PWM    = 2'b10,
    MODE_PULSE  = 2'b11
  } dct_mode_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } dct_act_e;
endpackage

// File: rtl/dct_counter.sv
module dct_counter
  import dct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dct_mode_e    mode,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         trigger,
  input  logic         clr_sel,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_p,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         tick,
  output logic         busy
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         run_q;
  logic         run_rise;
  logic         pulse_mode;
  logic         start;
  logic         at_period;
  logic         a_hit;
  logic         p_hit;
  logic [W-1:0] cnt_inc;
  logic [W-1:0] cnt_nx;

  always_comb begin
    run_rise   = run & ~run_q;
    pulse_mode = (mode == MODE_PULSE);
    start      = pulse_mode & trigger & ~busy;
    tick       = pulse_mode ? (busy & cnt_en) : (run & cnt_en & ~run_rise);
    at_period  = (cnt >= period);
    a_hit      = (cnt == cmp_a);
    p_hit      = (cnt == cmp_p) && (cmp_p != '0);
    cnt_inc    = cnt + ONE;
    case (mode)
      MODE_PWM, MODE_PULSE: cnt_nx = at_period ? '0 : cnt_inc;
      default: begin
        if (clr_sel) cnt_nx = a_hit ? '0 : cnt_inc;
        else         cnt_nx = p_hit ? '0 : cnt_inc;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else begin
      run_q <= run;
      if (!pulse_mode && run_rise) cnt <= '0;
      else if (start)              cnt <= '0;
      else if (tick)               cnt <= cnt_nx;
      if (!pulse_mode)             busy <= 1'b0;
      else if (start)              busy <= 1'b1;
      else if (tick && at_period)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dct_match.sv
module dct_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_p,
  output logic         flag_a,
  output logic         flag_p,
  output logic         flag_ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_p   <= 1'b0;
      flag_ovf <= 1'b0;
    end else begin
      flag_a   <= tick && (cnt == cmp_a);
      flag_p   <= tick && (cnt == cmp_p);
      flag_ovf <= tick && (cnt == CNT_MAX);
    end
  end
endmodule

// File: rtl/dct_outgen.sv
module dct_outgen
  import dct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dct_mode_e    mode,
  input  logic         run,
  input  logic         level,
  input  logic         polarity,
  input  dct_act_e     act,
  input  logic         tick,
  input  logic         busy,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] period,
  output logic         pin
);
  logic cmp_q;
  logic pwm_act;
  logic pulse_act;
  logic raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
    end else if (mode != MODE_CMPOUT || !run) begin
      cmp_q <= level;
    end else if (tick && cnt == cmp_a) begin
      case (act)
        ACT_LOW:    cmp_q <= 1'b0;
        ACT_HIGH:   cmp_q <= 1'b1;
        ACT_TOGGLE: cmp_q <= ~cmp_q;
        default:    cmp_q <= cmp_q;
      endcase
    end
  end

  always_comb begin
    pwm_act   = (duty != '0) && ((cnt < duty) || (duty >= period));
    pulse_act = busy && (cnt < duty);
    case (mode)
      MODE_CMPOUT: raw = cmp_q;
      MODE_PWM:    raw = pwm_act ? level : ~level;
      MODE_PULSE:  raw = pulse_act ? level : ~level;
      default:     raw = 1'b0;
    endcase
    pin = (mode == MODE_TIMER) ? 1'b0 : (raw ^ polarity);
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         level,
  input  logic         polarity,
  input  logic         swap,
  input  logic         clr_sel,
  input  logic [1:0]   act,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_p,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         trigger,
  output logic         pin,
  output logic         flag_a,
  output logic         flag_p,
  output logic         flag_ovf
);
  dct_mode_e    mode_e;
  dct_act_e     act_e;
  logic [W-1:0] period;
  logic [W-1:0] duty;
  logic [W-1:0] cnt;
  logic         tick;
  logic         busy;

  assign mode_e = dct_mode_e'(mode);
  assign act_e  = dct_act_e'(act);
  assign period = swap ? cmp_a : cmp_p;
  assign duty   = swap ? cmp_p : cmp_a;

  dct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .run(run), .cnt_en(cnt_en),
    .trigger(trigger), .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .period(period), .cnt(cnt), .tick(tick), .busy(busy)
  );

  dct_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_a(cmp_a),
    .cmp_p(cmp_p), .flag_a(flag_a), .flag_p(flag_p), .flag_ovf(flag_ovf)
  );

  dct_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .run(run), .level(level),
    .polarity(polarity), .act(act_e), .tick(tick), .busy(busy), .cnt(cnt),
    .cmp_a(cmp_a), .duty(duty), .period(period), .pin(pin)
  );
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         level,
  input logic         polarity,
  input logic         swap,
  input logic [W-1:0] cmp_a,
  input logic         run,
  input logic [W-1:0] cnt,
  input logic         pin,
  input logic         flag_a,
  input logic         flag_ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  p_timer_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !pin);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && mode != 2'b11) |=> $stable(cnt));

  p_ovf_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> ($past(cnt) == CNT_MAX));

  p_ovf_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ovf |-> (cnt == '0));

  p_flag_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_a |-> ($past(cnt) == $past(cmp_a)));

  p_pwm_zero_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !swap && cmp_a == '0) |-> (pin == (~level ^ polarity)));
endmodule

bind dual_cmp_timer dct_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .level(level), .polarity(polarity),
  .swap(swap), .cmp_a(cmp_a), .run(run), .cnt(cnt), .pin(pin),
  .flag_a(flag_a), .flag_ovf(flag_ovf)
);

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        lvl = 1'b0, pol = 1'b0, swp = 1'b0, csel = 1'b0;
  logic [1:0]  act = 2'b00;
  logic [15:0] a = '0, p = '0;
  logic        run = 1'b0, cen = 1'b0, trig = 1'b0;
  logic        pin, flag_a, flag_p, flag_ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cnt = '0;
  logic m_rq = 0, m_busy = 0, m_out = 0, m_fa = 0, m_fp = 0, m_fo = 0;

  always #10 clk = ~clk;

  dual_cmp_timer #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .level(lvl), .polarity(pol),
    .swap(swp), .clr_sel(csel), .act(act), .cmp_a(a), .cmp_p(p), .run(run),
    .cnt_en(cen), .trigger(trig), .pin(pin), .flag_a(flag_a),
    .flag_p(flag_p), .flag_ovf(flag_ovf)
  );

  task automatic m_step();
    logic rr, pulse, start, tick, atp;
    logic [15:0] per, nx;
    rr    = run && !m_rq;
    pulse = (mode == 2'b11);
    start = pulse && trig && !m_busy;
    tick  = pulse ? (m_busy && cen) : (run && cen && !rr);
    per   = swp ? a : p;
    atp   = (m_cnt >= per);
    m_fa  = tick && m_cnt == a;
    m_fp  = tick && m_cnt == p;
    m_fo  = tick && m_cnt == 16'hFFFF;
    if (mode != 2'b01 || !run) m_out = lvl;
    else if (tick && m_cnt == a) begin
      if (act == 2'b01) m_out = 1'b0;
      else if (act == 2'b10) m_out = 1'b1;
      else if (act == 2'b11) m_out = !m_out;
    end
    if (mode[1]) nx = atp ? 16'h0 : m_cnt + 16'h1;
    else if (csel) nx = (m_cnt == a) ? 16'h0 : m_cnt + 16'h1;
    else nx = (p != 0 && m_cnt == p) ? 16'h0 : m_cnt + 16'h1;
    if (!pulse) m_busy = 0;
    else if (start) m_busy = 1;
    else if (tick && atp) m_busy = 0;
    if (!pulse && rr) m_cnt = 0;
    else if (start) m_cnt = 0;
    else if (tick) m_cnt = nx;
    m_rq = run;
  endtask

  function automatic logic exp_pin();
    logic [15:0] per, dut;
    logic raw;
    per = swp ? a : p;
    dut = swp ? p : a;
    case (mode)
      2'b00: return 1'b0;
      2'b01: raw = m_out;
      2'b10: raw = ((dut != 0) && (m_cnt < dut || dut >= per)) ? lvl : !lvl;
      default: raw = (m_busy && m_cnt < dut) ? lvl : !lvl;
    endcase
    return raw ^ pol;
  endfunction

  task automatic chk(string tag, string what, logic act_v, logic exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    m_step();
    chk(tag, "pin", pin, exp_pin());
    chk(tag, "flag_a", flag_a, m_fa);
    chk(tag, "flag_p", flag_p, m_fp);
    chk(tag, "flag_ovf", flag_ovf, m_fo);
  endtask

  task automatic ncyc(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pin", pin, 1'b0);
    chk("R1", "flag_a", flag_a, 1'b0);
    chk("R1", "flag_p", flag_p, 1'b0);
    chk("R1", "flag_ovf", flag_ovf, 1'b0);
    rst_n = 1'b1;

    // R3: clear on A match
    mode = 2'b00; csel = 1; a = 3; p = 9; run = 1; cen = 1;
    ncyc("R3", 12);
    // R2: hold with run low, clear on run rise, gated counting
    run = 0; ncyc("R2", 5);
    run = 1;
    for (int i = 0; i < 30; i++) begin cen = 1'($urandom); cyc("R2"); end
    // R4: clear on non-zero P
    cen = 1; csel = 0; p = 4; a = 2;
    ncyc("R4", 14);
    // R4: overflow wrap with P zero
    run = 0; p = 0; a = 16'hFFF0; cyc("R4");
    run = 1; ncyc("R4", 65545);
    // R6: compare-output actions
    mode = 2'b01; lvl = 1; run = 0; csel = 1; a = 2; p = 5; ncyc("R6", 2);
    for (int k = 0; k < 4; k++) begin
      act = 2'(k); run = 1; ncyc("R6", 12); run = 0; ncyc("R6", 2);
    end
    // R7: polarity in compare mode and timer mode ignoring level/polarity
    pol = 1; act = 2'b11; run = 1; ncyc("R7", 10);
    mode = 2'b00;
    for (int i = 0; i < 10; i++) begin lvl = 1'($urandom); pol = 1'($urandom); cyc("R7"); end
    // R9: PWM duty cases
    mode = 2'b10; pol = 0; lvl = 1; swp = 0; run = 0; cyc("R9"); run = 1;
    a = 3; p = 7; ncyc("R9", 20);
    a = 0; p = 5; ncyc("R9", 10);
    a = 5; p = 5; ncyc("R9", 10);
    a = 8; p = 5; ncyc("R9", 10);
    lvl = 0; pol = 1; a = 2; p = 6; ncyc("R9", 16);
    // R8: swapped roles (period 9 from A, duty 2 from P)
    swp = 1; a = 9; p = 2; lvl = 1; pol = 0; ncyc("R8", 25);
    // R11: clr_sel ignored in waveform modes
    for (int i = 0; i < 30; i++) begin csel = 1'($urandom); cyc("R11"); end
    // R10: single pulse, retrigger while busy ignored, run irrelevant
    mode = 2'b11; swp = 0; a = 2; p = 6; run = 0; cen = 1; ncyc("R10", 3);
    trig = 1; cyc("R10"); trig = 0; ncyc("R10", 3);
    trig = 1; cyc("R10"); trig = 0; ncyc("R10", 10);
    csel = 1; trig = 1; cyc("R11"); trig = 0;
    for (int i = 0; i < 20; i++) begin cen = 1'($urandom); cyc("R10"); end
    // Random mix, flags checked every cycle
    for (int i = 0; i < 20000; i++) begin
      if (($urandom % 64) == 0) mode = 2'($urandom);
      lvl = 1'($urandom); pol = 1'($urandom); swp = 1'($urandom);
      csel = 1'($urandom); act = 2'($urandom);
      if (($urandom % 16) == 0) a = 16'($urandom % 12);
      if (($urandom % 16) == 0) p = 16'($urandom % 12);
      run = (($urandom % 32) != 0); cen = (($urandom % 4) != 0);
      trig = (($urandom % 8) == 0);
      cyc("R5");
    end
    finish_run();
  end
endmodule